// File: doc/BRIEF.md
# Wait-For-Interrupt Timeout Trap

This block watches the wait-for-interrupt (WFI) instruction on behalf of a processor core. When the core issues a WFI, the block puts the hart to sleep. It then waits for a wakeup, which is a pending enabled interrupt, or, when a timeout-wait control bit asks for it, for a bounded number of cycles to pass. A WFI issued in a mode below machine mode while the control bit is set may only sleep for `limit_i` cycles. If no wakeup arrives by then, the block raises a one-cycle illegal-instruction exception request instead of completing the WFI.

The core drives a one-cycle strobe with the WFI, together with its current privilege, the control bit and the limit. It then holds off retirement while `sleep_o` is high. The block ends each wait with exactly one result pulse: `wake_o` means the WFI completed normally, and `illegal_o` means the core must take an illegal-instruction trap. A limit of zero traps a covered WFI on the spot, without any sleep.

Top module: `wfi_timeout_trap`

## Requirements
- R1: After reset, and while `rst_ni` is low, `sleep_o`, `wake_o` and `illegal_o` are low. A reset asserted during a wait abandons that wait, and no result pulse follows it.
- R2: Privilege is encoded as user 2'b00, supervisor 2'b01 and machine 2'b11. A WFI accepted with `priv_i` = 2'b11 never produces `illegal_o`, whatever `tw_i` and `limit_i` are, and it sleeps until a wakeup.
- R3: A WFI accepted with `tw_i` = 0 never produces `illegal_o` in any mode, and it sleeps until a wakeup.
- R4: A WFI accepted with `tw_i` = 1, `priv_i` != 2'b11 and `limit_i` = L > 0, with no wakeup, holds `sleep_o` high for L cycles. `illegal_o` is then high in the cycle L clock edges after the accepting edge, and `sleep_o` is low in that same cycle.
- R5: With `tw_i` = 1, `priv_i` != 2'b11 and `limit_i` = 0, an accepted WFI raises `illegal_o` in the cycle right after the accepting edge, never raises `sleep_o`, and ignores a wakeup that arrives with it.
- R6: A wakeup sampled at clock edge w after acceptance, with 1 <= w <= L (or any w >= 1 when no trap is armed), ends the wait. `wake_o` is high and `sleep_o` is low in the cycle after that edge, and no `illegal_o` is raised. The wakeup wins on the very edge at which the limit would expire.
- R7: A WFI accepted with `wake_i` already high, and not trapped under R5, completes at once. `wake_o` is high in the next cycle and `sleep_o` never rises.
- R8: A WFI strobe that arrives while a wait is in progress is ignored. It neither restarts the wait nor alters its outcome.
- R9: Privilege, `tw_i` and `limit_i` are sampled only at acceptance. Changes to them during a wait do not alter its outcome or its timing.
- R10: `wake_o` and `illegal_o` are one-cycle pulses, at most one per accepted WFI, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wfi_valid_i | input | 1 | One-cycle strobe, a WFI instruction is issued |
| priv_i | input | 2 | Privilege of the issuing instruction (2'b11 machine) |
| tw_i | input | 1 | Timeout-wait control bit |
| wake_i | input | 1 | Pending enabled interrupt, wakes the hart |
| limit_i | input | CW | Timeout bound in cycles, 0 traps at once |
| sleep_o | output | 1 | A WFI is waiting, hold the hart |
| wake_o | output | 1 | Pulse, the WFI completed normally |
| illegal_o | output | 1 | Pulse, raise an illegal-instruction exception |

## Verification
The hardest situation to reach from the ports is a wait whose outcome must ignore everything that changes after acceptance: a second strobe, a flipped control bit, a different privilege and a new limit, all arriving during the wait. Every table row therefore scrambles all four inputs one cycle after acceptance, in the direction that would change the result if the design sampled them late. The rows also place the wakeup on the exact edge where the limit expires, and together with the strobe when the limit is zero, so both orders of the wake-against-trap race are seen. A directed reset in the middle of a long armed wait shows that the abandoned wait leaves no result pulse.

// File: rtl/wfi_to_pkg.sv
package wfi_to_pkg;
  localparam logic [1:0] PRIV_USER       = 2'b00;
  localparam logic [1:0] PRIV_SUPERVISOR = 2'b01;
  localparam logic [1:0] PRIV_MACHINE    = 2'b11;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } wfi_state_e;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_WAKE = 2'b01,
    RES_TRAP = 2'b10
  } wfi_result_e;
endpackage

// File: rtl/wfi_to_arm.sv
module wfi_to_arm
  import wfi_to_pkg::*;
(
  input  logic       tw_i,
  input  logic [1:0] priv_i,
  output logic       arm_o
);
  // timeout applies only below machine mode
  assign arm_o = tw_i && (priv_i != PRIV_MACHINE);
endmodule

// File: rtl/wfi_to_timer.sv
module wfi_to_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] lim_i,
  input  logic          run_i,
  output logic          zero_o,
  output logic          expire_o
);
  localparam int unsigned CW1 = CW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic [CW1-1:0] cnt_nxt;

  assign zero_o  = (lim_i == '0);
  assign cnt_nxt = {1'b0, cnt_q} + CW1'(1);
  // expires on the edge that would make the count reach the bound
  assign expire_o = run_i && (cnt_nxt == {1'b0, lim_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= lim_i;
    end else if (run_i && (cnt_q != lim_q)) begin
      cnt_q <= cnt_nxt[CW-1:0];
    end
  end
endmodule

// File: rtl/wfi_to_fsm.sv
module wfi_to_fsm
  import wfi_to_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wfi_valid_i,
  input  logic wake_i,
  input  logic arm_i,
  input  logic lim_zero_i,
  input  logic expire_i,
  output logic load_o,
  output logic run_o,
  output logic sleep_o,
  output logic wake_o,
  output logic illegal_o
);
  wfi_state_e  state_q, state_d;
  logic        armed_q, armed_d;
  wfi_result_e res_q, res_d;

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    res_d   = RES_NONE;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wfi_valid_i) begin
          if (arm_i && lim_zero_i) begin
            res_d = RES_TRAP;
          end else if (wake_i) begin
            res_d = RES_WAKE;
          end else begin
            state_d = ST_WAIT;
            armed_d = arm_i;
            load_o  = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        // strobes are ignored here; wakeup beats expiry on the same edge
        if (wake_i) begin
          res_d   = RES_WAKE;
          state_d = ST_IDLE;
        end else if (armed_q && expire_i) begin
          res_d   = RES_TRAP;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
      res_q   <= RES_NONE;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      res_q   <= res_d;
    end
  end

  assign run_o     = (state_q == ST_WAIT) && armed_q;
  assign sleep_o   = (state_q == ST_WAIT);
  assign wake_o    = (res_q == RES_WAKE);
  assign illegal_o = (res_q == RES_TRAP);
endmodule

// File: rtl/wfi_timeout_trap.sv
module wfi_timeout_trap #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wfi_valid_i,
  input  logic [1:0]    priv_i,
  input  logic          tw_i,
  input  logic          wake_i,
  input  logic [CW-1:0] limit_i,
  output logic          sleep_o,
  output logic          wake_o,
  output logic          illegal_o
);
  logic arm, lim_zero, expire, load, run;

  wfi_to_arm i_arm (
    .tw_i   (tw_i),
    .priv_i (priv_i),
    .arm_o  (arm)
  );

  wfi_to_timer #(.CW(CW)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .lim_i    (limit_i),
    .run_i    (run),
    .zero_o   (lim_zero),
    .expire_o (expire)
  );

  wfi_to_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wfi_valid_i (wfi_valid_i),
    .wake_i      (wake_i),
    .arm_i       (arm),
    .lim_zero_i  (lim_zero),
    .expire_i    (expire),
    .load_o      (load),
    .run_o       (run),
    .sleep_o     (sleep_o),
    .wake_o      (wake_o),
    .illegal_o   (illegal_o)
  );
endmodule

// File: rtl/wfi_timeout_trap_chk.sv
module wfi_timeout_trap_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wfi_valid_i,
  input logic [1:0]    priv_i,
  input logic          tw_i,
  input logic          wake_i,
  input logic [CW-1:0] limit_i,
  input logic          sleep_o,
  input logic          wake_o,
  input logic          illegal_o
);
  logic          accept;
  logic          chk_armed;
  logic [CW-1:0] chk_lim;
  logic [CW:0]   chk_cnt;

  assign accept = wfi_valid_i && !sleep_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_armed <= 1'b0;
      chk_lim   <= '0;
      chk_cnt   <= '0;
    end else if (accept) begin
      chk_armed <= tw_i && (priv_i != 2'b11);
      chk_lim   <= limit_i;
      chk_cnt   <= '0;
    end else if (sleep_o && (chk_cnt != {1'b0, {CW{1'b1}}})) begin
      chk_cnt <= chk_cnt + 1'b1;
    end
  end

  AST_ILLEGAL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o); // R10
  AST_WAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R10
  AST_RESULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wake_o && illegal_o)); // R10
  AST_NO_TRAP_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> chk_armed); // R2, R3
  AST_TIMEOUT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (chk_cnt == {1'b0, chk_lim}) && !sleep_o); // R4
  AST_ZERO_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && tw_i && (priv_i != 2'b11) && (limit_i == '0) |=> illegal_o && !sleep_o); // R5
  AST_WAKE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o && wake_i |=> wake_o && !sleep_o); // R6
  AST_WAKE_IN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && wake_i && !(tw_i && (priv_i != 2'b11) && (limit_i == '0)) |=> wake_o && !sleep_o); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !sleep_o && !wake_o && !illegal_o); // R1
endmodule

bind wfi_timeout_trap wfi_timeout_trap_chk #(.CW(CW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wfi_valid_i (wfi_valid_i),
  .priv_i      (priv_i),
  .tw_i        (tw_i),
  .wake_i      (wake_i),
  .limit_i     (limit_i),
  .sleep_o     (sleep_o),
  .wake_o      (wake_o),
  .illegal_o   (illegal_o)
);

// File: tb/test_wfi_timeout_trap.sv
`timescale 1ns/1ps
module test_wfi_timeout_trap;
  localparam int CW = 8;
  localparam int NV = 13;
  localparam logic [7:0] NEVER = 8'd99;

  // {tw, priv, limit, wake_at, exp_illegal, exp_latency}
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'd4, NEVER, 1'b1, 8'd4},
    {1'b1, 2'd1, 8'd1, NEVER, 1'b1, 8'd1},
    {1'b1, 2'd0, 8'd0, 8'd0,  1'b1, 8'd0},
    {1'b1, 2'd1, 8'd0, NEVER, 1'b1, 8'd0},
    {1'b1, 2'd0, 8'd5, 8'd3,  1'b0, 8'd3},
    {1'b1, 2'd0, 8'd5, 8'd5,  1'b0, 8'd5},
    {1'b1, 2'd3, 8'd2, 8'd9,  1'b0, 8'd9},
    {1'b1, 2'd3, 8'd0, 8'd4,  1'b0, 8'd4},
    {1'b0, 2'd0, 8'd2, 8'd7,  1'b0, 8'd7},
    {1'b0, 2'd0, 8'd0, 8'd0,  1'b0, 8'd0},
    {1'b1, 2'd0, 8'd3, 8'd0,  1'b0, 8'd0},
    {1'b1, 2'd1, 8'd7, NEVER, 1'b1, 8'd7},
    {1'b0, 2'd1, 8'd0, 8'd3,  1'b0, 8'd3}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wfi_valid_i = 1'b0;
  logic [1:0]    priv_i = 2'd0;
  logic          tw_i = 1'b0;
  logic          wake_i = 1'b0;
  logic [CW-1:0] limit_i = '0;
  logic          sleep_o, wake_o, illegal_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  wfi_timeout_trap #(.CW(CW)) i_wfi_timeout_trap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wfi_valid_i (wfi_valid_i),
    .priv_i      (priv_i),
    .tw_i        (tw_i),
    .wake_i      (wake_i),
    .limit_i     (limit_i),
    .sleep_o     (sleep_o),
    .wake_o      (wake_o),
    .illegal_o   (illegal_o)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic tw_v, ill_e, got, ill_g, sleep_bad, both;
    logic [1:0] pr_v;
    logic [7:0] lim_v, wk, lat_e;
    int lat_g;
    string tag;

    #1;
    check(!sleep_o && !wake_o && !illegal_o, "R1 outputs in reset", {sleep_o, wake_o, illegal_o}, 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!sleep_o && !wake_o && !illegal_o, "R1 outputs after reset", {sleep_o, wake_o, illegal_o}, 0);

    for (int r = 0; r < NV; r++) begin
      {tw_v, pr_v, lim_v, wk, ill_e, lat_e} = VEC[r];
      if (ill_e) tag = (lim_v == 0) ? "R5" : "R4";
      else if (wk == 0) tag = "R7";
      else if (pr_v == 2'd3) tag = "R2";
      else if (!tw_v) tag = "R3";
      else tag = "R6";
      got = 0; ill_g = 0; lat_g = -1; sleep_bad = 0; both = 0;
      for (int k = 0; k < 40 && !got; k++) begin
        if (k == 0) begin
          wfi_valid_i = 1'b1; tw_i = tw_v; priv_i = pr_v; limit_i = lim_v;
        end else begin
          // R8 R9: re-strobe and scramble sampled inputs during the wait
          wfi_valid_i = (k == 1) && (lat_e > 1);
          if (k == 1) begin
            tw_i = !tw_v; priv_i = (pr_v == 2'd3) ? 2'd0 : 2'd3; limit_i = '0;
          end
        end
        wake_i = (k == int'(wk));
        @(posedge clk_i); #1;
        if (wake_o || illegal_o) begin
          got = 1; lat_g = k; ill_g = illegal_o; both = wake_o && illegal_o;
          if (sleep_o) sleep_bad = 1;
        end else if (!sleep_o) begin
          sleep_bad = 1;
        end
        @(negedge clk_i);
      end
      wfi_valid_i = 1'b0; wake_i = 1'b0;
      check(got && ill_g == ill_e, {tag, " R8 R9 result kind"}, ill_g, ill_e);
      check(lat_g == int'(lat_e), {tag, " R8 R9 result latency"}, lat_g, lat_e);
      check(!sleep_bad, {tag, " sleep_o held during wait only"}, sleep_bad, 0);
      @(posedge clk_i); #1;
      check(!both && !wake_o && !illegal_o && !sleep_o, "R10 single pulse", {wake_o, illegal_o}, 0);
      @(negedge clk_i);
    end

    // R1: reset in the middle of an armed wait abandons it
    wfi_valid_i = 1'b1; tw_i = 1'b1; priv_i = 2'd0; limit_i = 8'd30;
    @(negedge clk_i);
    wfi_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(sleep_o, "R4 sleeping before reset", sleep_o, 1);
    rst_ni = 1'b0; #1;
    check(!sleep_o, "R1 async reset clears sleep", sleep_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    ill_g = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk_i); #1;
      if (illegal_o || wake_o || sleep_o) ill_g = 1;
    end
    check(!ill_g, "R1 no result after reset mid-wait", ill_g, 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule